// File: doc/BRIEF.md
# Cartridge ROM/RAM Bank Controller

This block is the banking logic of an 8-bit handheld cartridge. It sits on the console's 16-bit address bus and turns CPU writes into the read-only ROM area into control register updates: a RAM enable, a 7-bit switchable ROM bank, a 4-bit select that picks a RAM bank or a clock register, and a latch strobe for the clock. Reads are translated into a wide physical ROM address or a RAM address, with chip selects toward the external memories and a read-data multiplexer back to the console.

The lower 16 KiB of the bus always shows ROM bank 0. The upper 16 KiB shows the bank held in the bank register. The 8 KiB external window at 0xA000 shows one of eight RAM banks or one of five clock registers. The clock counters are not part of this block. A five-entry register file stands in for them, with live copies that the bus writes and latched copies that the bus reads. Any device that is disabled, absent or unmapped reads back as 0xFF.

Top module: `cart_bank_ctrl`

## Requirements
- R1: After reset the ROM bank is 1, the RAM/clock select is 0 and RAM is disabled, so a read at 0x4000..0x7FFF drives rom_addr equal to the bus address and a read at 0xA000..0xBFFF returns 0xFF.
- R2: A write anywhere in 0x0000..0x1FFF enables RAM and clock access when bits [3:0] of the data equal 0xA, and disables it for any other value.
- R3: A write in 0x2000..0x3FFF loads the ROM bank with data bits [6:0]. A result of 0 is stored as 1, and bit 7 is ignored.
- R4: A write in 0x4000..0x5FFF loads the RAM/clock select with data bits [3:0].
- R5: A read in 0x0000..0x3FFF asserts rom_cs and drives rom_addr equal to the bus address, whatever the bank, and bus_rdata returns rom_rdata.
- R6: A read in 0x4000..0x7FFF asserts rom_cs and drives rom_addr = bank*0x4000 + (addr - 0x4000), and bus_rdata returns rom_rdata.
- R7: With RAM enabled and select 0..7, an access in 0xA000..0xBFFF drives ram_addr = select*0x2000 + (addr - 0xA000) and asserts ram_cs. A write also asserts ram_we with ram_wdata equal to the bus data, and a read returns ram_rdata.
- R8: While RAM is disabled, reads in 0xA000..0xBFFF return 0xFF, and writes there assert neither ram_we nor ram_cs and change no clock register.
- R9: With RAM enabled, a clock fitted and select 0x08..0x0C, a write in 0xA000..0xBFFF stores the data in live clock register select-8, and a read returns the latched copy of that register.
- R10: A write in 0x6000..0x7FFF with a clock fitted copies all five live clock registers into their latched copies. All clock registers are 0 after reset.
- R11: With no clock fitted, clock register reads return 0xFF, and clock register writes and latch writes are ignored.
- R12: Select values 0x0D..0x0F read 0xFF in 0xA000..0xBFFF and ignore writes. Reads in 0x8000..0x9FFF and 0xC000..0xFFFF return 0xFF.
- R13: rom_cs is asserted only for reads in 0x0000..0x7FFF, never during writes, and rom_cs and ram_cs are never asserted together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low cartridge power-up reset |
| bus_addr | input | 16 | Console address |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 8 | Console write data |
| bus_rdata | output | 8 | Read data returned to the console |
| rom_addr | output | 21 | Physical ROM byte address |
| rom_cs | output | 1 | ROM chip select |
| rom_rdata | input | 8 | ROM read data |
| ram_addr | output | 16 | Physical RAM byte address |
| ram_cs | output | 1 | RAM chip select |
| ram_we | output | 1 | RAM write enable |
| ram_wdata | output | 8 | RAM write data |
| ram_rdata | input | 8 | RAM read data |
| clock_fitted | input | 1 | High when the cartridge carries a clock |

## Verification
The assertions assume that bus_rd and bus_wr are never high together, that a write strobe lasts exactly one clock, and that clock_fitted changes only while the bus is idle. The stimulus tasks raise one strobe at a time on the falling edge and drop it on the next falling edge. The bench changes clock_fitted only between transfers. Read data is checked combinationally in the same cycle, against ROM and RAM models in the bench that hold no state from the design.

// File: rtl/cbc_pkg.sv
package cbc_pkg;

  // Bus map constants: these are part of the console's address map.
  localparam int BUS_AW      = 16;
  localparam int ROM_OFS_W   = 14;   // 16 KiB ROM window
  localparam int RAM_OFS_W   = 13;   // 8 KiB external window
  localparam logic [3:0] EN_KEY = 4'hA;

  // Which part of the bus an address falls in.
  typedef enum logic [1:0] {
    WIN_ROM_FIXED = 2'd0,
    WIN_ROM_BANK  = 2'd1,
    WIN_EXT       = 2'd2,
    WIN_NONE      = 2'd3
  } win_e;

  // What the RAM/clock select points at.
  typedef enum logic [1:0] {
    SEL_RAM   = 2'd0,
    SEL_CLOCK = 2'd1,
    SEL_VOID  = 2'd2
  } sel_kind_e;

  // Control register targeted by a write into ROM space (addr[14:13]).
  typedef enum logic [1:0] {
    CR_ENABLE = 2'd0,
    CR_BANK   = 2'd1,
    CR_SELECT = 2'd2,
    CR_LATCH  = 2'd3
  } creg_e;

endpackage

// File: rtl/cbc_ctrl_regs.sv
module cbc_ctrl_regs
  import cbc_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int ROM_BANK_W = 7,
  parameter int SEL_W      = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic [2:0]            addr_top,     // bus_addr[15:13]
  input  logic [DATA_W-1:0]     wdata,
  output logic                  ram_en,
  output logic [ROM_BANK_W-1:0] rom_bank,
  output logic [SEL_W-1:0]      sel,
  output logic                  latch_stb
);

  logic  ctl_wr;
  creg_e target;
  logic  wr_enable, wr_bank, wr_select;
  logic [DATA_W-1:0] unused_wdata;

  assign ctl_wr    = wr_en && !addr_top[2];
  assign target    = creg_e'(addr_top[1:0]);
  assign wr_enable = ctl_wr && (target == CR_ENABLE);
  assign wr_bank   = ctl_wr && (target == CR_BANK);
  assign wr_select = ctl_wr && (target == CR_SELECT);
  assign latch_stb = ctl_wr && (target == CR_LATCH);
  assign unused_wdata = wdata;

  function automatic logic [ROM_BANK_W-1:0] bank_of(input logic [DATA_W-1:0] d);
    logic [ROM_BANK_W-1:0] b;
    b = d[ROM_BANK_W-1:0];
    return (b == '0) ? ROM_BANK_W'(1) : b;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ram_en   <= 1'b0;
      rom_bank <= ROM_BANK_W'(1);
      sel      <= '0;
    end else begin
      if (wr_enable) ram_en   <= (wdata[3:0] == EN_KEY);
      if (wr_bank)   rom_bank <= bank_of(wdata);
      if (wr_select) sel      <= wdata[SEL_W-1:0];
    end
  end

  AST_BANK_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    rom_bank != '0); // R3
  AST_SEL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_select |=> $stable(sel)); // R4
  AST_EN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_enable |=> $stable(ram_en)); // R2

endmodule

// File: rtl/cbc_addr_map.sv
module cbc_addr_map
  import cbc_pkg::*;
#(
  parameter int ROM_BANK_W = 7,
  parameter int SEL_W      = 4,
  parameter int RAM_BANKS  = 8,
  parameter int CLK_REGS   = 5,
  localparam int RAM_BANK_W = $clog2(RAM_BANKS),
  localparam int ROM_AW     = ROM_BANK_W + ROM_OFS_W,
  localparam int RAM_AW     = RAM_BANK_W + RAM_OFS_W
) (
  input  logic [BUS_AW-1:0]     addr,
  input  logic [ROM_BANK_W-1:0] rom_bank,
  input  logic [SEL_W-1:0]      sel,
  output win_e                  win,
  output sel_kind_e             sel_kind,
  output logic [ROM_AW-1:0]     rom_addr,
  output logic [RAM_AW-1:0]     ram_addr
);

  function automatic win_e window_of(input logic [BUS_AW-1:0] a);
    case (a[15:13])
      3'b000, 3'b001: return WIN_ROM_FIXED;
      3'b010, 3'b011: return WIN_ROM_BANK;
      3'b101:         return WIN_EXT;
      default:        return WIN_NONE;
    endcase
  endfunction

  function automatic sel_kind_e kind_of(input logic [SEL_W-1:0] s);
    if (int'(s) < RAM_BANKS)                 return SEL_RAM;
    if (int'(s) < RAM_BANKS + CLK_REGS)      return SEL_CLOCK;
    return SEL_VOID;
  endfunction

  // Fixed window reads bank 0, switched window reads the selected bank.
  function automatic logic [ROM_AW-1:0] rom_phys(input logic [BUS_AW-1:0] a,
                                                 input logic [ROM_BANK_W-1:0] b);
    logic [ROM_BANK_W-1:0] eff;
    eff = a[14] ? b : '0;
    return {eff, a[ROM_OFS_W-1:0]};
  endfunction

  function automatic logic [RAM_AW-1:0] ram_phys(input logic [BUS_AW-1:0] a,
                                                 input logic [SEL_W-1:0] s);
    return {s[RAM_BANK_W-1:0], a[RAM_OFS_W-1:0]};
  endfunction

  assign win      = window_of(addr);
  assign sel_kind = kind_of(sel);
  assign rom_addr = rom_phys(addr, rom_bank);
  assign ram_addr = ram_phys(addr, sel);

endmodule

// File: rtl/cbc_clock_file.sv
module cbc_clock_file #(
  parameter int DATA_W   = 8,
  parameter int CLK_REGS = 5,
  parameter int IDX_W    = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fitted,
  input  logic              wr_go,
  input  logic [IDX_W-1:0]  idx,
  input  logic [DATA_W-1:0] wdata,
  input  logic              latch_stb,
  output logic [DATA_W-1:0] rd_data
);

  logic [CLK_REGS-1:0][DATA_W-1:0] live;
  logic [CLK_REGS-1:0][DATA_W-1:0] held;
  logic latch_go;

  assign latch_go = latch_stb && fitted;

  for (genvar g = 0; g < CLK_REGS; g++) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        live[g] <= '0;
        held[g] <= '0;
      end else begin
        if (wr_go && (int'(idx) == g)) live[g] <= wdata;
        if (latch_go)                  held[g] <= live[g];
      end
    end
  end

  always_comb begin
    rd_data = '1;
    for (int k = 0; k < CLK_REGS; k++)
      if (int'(idx) == k) rd_data = held[k];
  end

  AST_NOFIT_NO_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
    !fitted |=> $stable(held)); // R11
  AST_IDLE_LIVE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_go |=> $stable(live)); // R9

endmodule

// File: rtl/cart_bank_ctrl.sv
module cart_bank_ctrl
  import cbc_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int ROM_BANK_W = 7,
  parameter int SEL_W      = 4,
  parameter int RAM_BANKS  = 8,
  parameter int CLK_REGS   = 5,
  localparam int RAM_BANK_W = $clog2(RAM_BANKS),
  localparam int ROM_AW     = ROM_BANK_W + ROM_OFS_W,
  localparam int RAM_AW     = RAM_BANK_W + RAM_OFS_W,
  localparam int CIDX_W     = $clog2(CLK_REGS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [BUS_AW-1:0] bus_addr,
  input  logic              bus_rd,
  input  logic              bus_wr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic [ROM_AW-1:0] rom_addr,
  output logic              rom_cs,
  input  logic [DATA_W-1:0] rom_rdata,
  output logic [RAM_AW-1:0] ram_addr,
  output logic              ram_cs,
  output logic              ram_we,
  output logic [DATA_W-1:0] ram_wdata,
  input  logic [DATA_W-1:0] ram_rdata,
  input  logic              clock_fitted
);

  logic                  ram_en;
  logic [ROM_BANK_W-1:0] rom_bank;
  logic [SEL_W-1:0]      sel;
  logic                  latch_stb;
  win_e                  win;
  sel_kind_e             sel_kind;
  logic [DATA_W-1:0]     clk_rd;

  // Named internal events.
  logic ext_hit;       // access in the external window
  logic ram_access;    // enabled access to a RAM bank
  logic clock_access;  // enabled access to a fitted clock register
  logic clock_wr;

  cbc_ctrl_regs #(
    .DATA_W(DATA_W), .ROM_BANK_W(ROM_BANK_W), .SEL_W(SEL_W)
  ) i_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(bus_wr), .addr_top(bus_addr[15:13]),
    .wdata(bus_wdata), .ram_en(ram_en), .rom_bank(rom_bank), .sel(sel),
    .latch_stb(latch_stb)
  );

  cbc_addr_map #(
    .ROM_BANK_W(ROM_BANK_W), .SEL_W(SEL_W), .RAM_BANKS(RAM_BANKS), .CLK_REGS(CLK_REGS)
  ) i_map (
    .addr(bus_addr), .rom_bank(rom_bank), .sel(sel), .win(win),
    .sel_kind(sel_kind), .rom_addr(rom_addr), .ram_addr(ram_addr)
  );

  assign ext_hit      = (win == WIN_EXT);
  assign ram_access   = ext_hit && ram_en && (sel_kind == SEL_RAM);
  assign clock_access = ext_hit && ram_en && (sel_kind == SEL_CLOCK) && clock_fitted;
  assign clock_wr     = clock_access && bus_wr;

  cbc_clock_file #(
    .DATA_W(DATA_W), .CLK_REGS(CLK_REGS), .IDX_W(CIDX_W)
  ) i_clock (
    .clk(clk), .rst_n(rst_n), .fitted(clock_fitted), .wr_go(clock_wr),
    .idx(CIDX_W'(sel - SEL_W'(RAM_BANKS))), .wdata(bus_wdata),
    .latch_stb(latch_stb), .rd_data(clk_rd)
  );

  assign rom_cs    = bus_rd && ((win == WIN_ROM_FIXED) || (win == WIN_ROM_BANK));
  assign ram_cs    = ram_access && (bus_rd || bus_wr);
  assign ram_we    = ram_access && bus_wr;
  assign ram_wdata = bus_wdata;

  always_comb begin
    bus_rdata = '1;
    case (win)
      WIN_ROM_FIXED, WIN_ROM_BANK: bus_rdata = rom_rdata;
      WIN_EXT: begin
        if (ram_access)        bus_rdata = ram_rdata;
        else if (clock_access) bus_rdata = clk_rd;
      end
      default: bus_rdata = '1;
    endcase
  end

  AST_WE_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    ram_we |-> ram_en); // R8
  AST_DISABLED_FF: assert property (@(posedge clk) disable iff (!rst_n)
    (ext_hit && !ram_en) |-> (bus_rdata == '1)); // R8
  AST_VOID_SEL_FF: assert property (@(posedge clk) disable iff (!rst_n)
    (ext_hit && (sel_kind == SEL_VOID)) |-> ((bus_rdata == '1) && !ram_we)); // R12
  AST_CS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rom_cs, ram_cs})); // R13
  AST_ROM_CS_READ_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    rom_cs |-> bus_rd); // R13

endmodule

// File: tb/test_cart_bank_ctrl.sv
`timescale 1ns/1ps
module test_cart_bank_ctrl;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] bus_addr = '0;
  logic        bus_rd = 1'b0, bus_wr = 1'b0;
  logic [7:0]  bus_wdata = '0;
  logic [7:0]  bus_rdata;
  logic [20:0] rom_addr;
  logic        rom_cs;
  logic [7:0]  rom_rdata;
  logic [15:0] ram_addr;
  logic        ram_cs, ram_we;
  logic [7:0]  ram_wdata, ram_rdata;
  logic        clock_fitted = 1'b1;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  cart_bank_ctrl i_cart_bank_ctrl (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .rom_addr(rom_addr), .rom_cs(rom_cs),
    .rom_rdata(rom_rdata), .ram_addr(ram_addr), .ram_cs(ram_cs), .ram_we(ram_we),
    .ram_wdata(ram_wdata), .ram_rdata(ram_rdata), .clock_fitted(clock_fitted)
  );

  // ROM model: a pure function of the address.
  function automatic logic [7:0] rom_val(input logic [20:0] a);
    return a[7:0] ^ {1'b0, a[20:14]};
  endfunction
  assign rom_rdata = rom_val(rom_addr);

  // RAM model: small store indexed by bank and low offset bits.
  logic [7:0] mem [256];
  initial for (int i = 0; i < 256; i++) mem[i] = 8'h00;
  always @(posedge clk) if (ram_we) mem[{ram_addr[15:13], ram_addr[4:0]}] <= ram_wdata;
  assign ram_rdata = mem[{ram_addr[15:13], ram_addr[4:0]}];

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr_start(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_rd = 1'b0; bus_wr = 1'b1;
    #1;
  endtask

  task automatic wr_end();
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_write(input logic [15:0] a, input logic [7:0] d);
    wr_start(a, d);
    wr_end();
  endtask

  task automatic bus_read(input logic [15:0] a);
    @(negedge clk);
    bus_addr = a; bus_wr = 1'b0; bus_rd = 1'b1;
    #1;
  endtask

  // Stimulus table: {bank value written, read address}.
  localparam logic [23:0] VEC [8] = '{
    {8'h00, 16'h4000}, {8'h01, 16'h7FFF}, {8'h02, 16'h4001}, {8'h7F, 16'h5ABC},
    {8'h80, 16'h6000}, {8'h81, 16'h0123}, {8'h45, 16'h3FFF}, {8'hFF, 16'h7001}
  };

  function automatic logic [20:0] exp_rom(input logic [7:0] wb, input logic [15:0] a);
    int bank;
    bank = wb % 128;
    if (bank == 0) bank = 1;
    if (a < 16'h4000) return 21'(a);
    return 21'(bank * 32'h4000 + (int'(a) - 32'h4000));
  endfunction

  initial begin
    #(4 * 150000);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [20:0] ea;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state
    bus_read(16'h4123);
    chk("R1 bank after reset", rom_addr, 21'h04123);
    bus_read(16'hA010);
    chk("R1 RAM disabled after reset", bus_rdata, 8'hFF);
    chk("R1 ram_cs low when disabled", ram_cs, 1'b0);

    // R3/R5/R6: table-driven ROM mapping
    foreach (VEC[i]) begin
      bus_write(16'h2000 | 16'(i * 16'h0111), VEC[i][23:16]);
      bus_read(VEC[i][15:0]);
      ea = exp_rom(VEC[i][23:16], VEC[i][15:0]);
      chk(VEC[i][15:0] < 16'h4000 ? "R5 fixed rom_addr" : "R6 R3 banked rom_addr", rom_addr, ea);
      chk("R5 R6 rom_cs on read", rom_cs, 1'b1);
      chk("R5 R6 rdata from ROM", bus_rdata, rom_val(ea));
    end

    // R13: writes into ROM space never select the ROM
    wr_start(16'h3000, 8'h05);
    chk("R13 rom_cs low during write", rom_cs, 1'b0);
    wr_end();

    // R8: writes while disabled are dropped
    bus_write(16'h4000, 8'h00);
    wr_start(16'hA010, 8'h55);
    chk("R8 ram_we low while disabled", ram_we, 1'b0);
    chk("R8 ram_cs low while disabled", ram_cs, 1'b0);
    wr_end();
    bus_write(16'h0000, 8'h0A);
    bus_read(16'hA010);
    chk("R8 disabled write discarded", bus_rdata, 8'h00);

    // R4/R7: select 3 via masked value, write and read RAM
    bus_write(16'h4000, 8'h13);
    wr_start(16'hA123, 8'h5A);
    chk("R7 ram_addr bank 3", ram_addr, 16'h6123);
    chk("R7 ram_we on enabled write", ram_we, 1'b1);
    chk("R7 ram_wdata", ram_wdata, 8'h5A);
    chk("R13 cs exclusive", {rom_cs, ram_cs}, 2'b01);
    wr_end();
    bus_read(16'hA123);
    chk("R4 R7 read back bank 3", bus_rdata, 8'h5A);
    bus_write(16'h5FFF, 8'h00);
    bus_read(16'hA123);
    chk("R7 ram_addr bank 0", ram_addr, 16'h0123);
    chk("R7 bank 0 separate", bus_rdata, 8'h00);

    // R2: enable key decoding
    bus_write(16'h4000, 8'h03);
    bus_write(16'h1FFF, 8'h0B);
    bus_read(16'hA123);
    chk("R2 non-key disables", bus_rdata, 8'hFF);
    bus_write(16'h0800, 8'hFA);
    bus_read(16'hA123);
    chk("R2 low nibble A enables", bus_rdata, 8'h5A);

    // R9/R10: clock registers with clock fitted
    clock_fitted = 1'b1;
    bus_write(16'h4000, 8'h08);
    bus_write(16'hA000, 8'h11);
    bus_write(16'h4000, 8'h0C);
    bus_write(16'hA5A5, 8'h44);
    bus_read(16'hA5A5);
    chk("R9 read returns latched copy", bus_rdata, 8'h00);
    bus_write(16'h6000, 8'h01);
    bus_read(16'hB000);
    chk("R10 latch copies reg 4", bus_rdata, 8'h44);
    bus_write(16'h4000, 8'h08);
    bus_read(16'hA000);
    chk("R10 latch copies reg 0", bus_rdata, 8'h11);

    // R8: clock registers also blocked while disabled
    bus_write(16'h0000, 8'h00);
    bus_read(16'hA000);
    chk("R8 clock read while disabled", bus_rdata, 8'hFF);
    bus_write(16'h0000, 8'h0A);

    // R11: no clock fitted
    @(negedge clk); bus_rd = 1'b0; clock_fitted = 1'b0;
    bus_write(16'h4000, 8'h09);
    bus_read(16'hA000);
    chk("R11 absent clock reads FF", bus_rdata, 8'hFF);
    bus_write(16'hA000, 8'h77);
    bus_write(16'h7FFF, 8'h01);
    @(negedge clk); bus_rd = 1'b0; clock_fitted = 1'b1;
    bus_read(16'hA000);
    chk("R11 absent latch ignored", bus_rdata, 8'h00);
    bus_write(16'h6000, 8'h01);
    bus_read(16'hA000);
    chk("R11 absent write ignored", bus_rdata, 8'h00);

    // R12: void select and unmapped windows
    bus_write(16'h4000, 8'h0D);
    bus_read(16'hA000);
    chk("R12 select 0x0D reads FF", bus_rdata, 8'hFF);
    wr_start(16'hA000, 8'h99);
    chk("R12 select 0x0D no ram_we", ram_we, 1'b0);
    wr_end();
    bus_write(16'h4000, 8'h0F);
    bus_read(16'hBFFF);
    chk("R12 select 0x0F reads FF", bus_rdata, 8'hFF);
    bus_read(16'h8000);
    chk("R12 0x8000 reads FF", bus_rdata, 8'hFF);
    chk("R13 rom_cs low outside ROM", rom_cs, 1'b0);
    bus_read(16'hC000);
    chk("R12 0xC000 reads FF", bus_rdata, 8'hFF);
    bus_read(16'hFFFF);
    chk("R12 0xFFFF reads FF", bus_rdata, 8'hFF);

    // R1: reset again restores defaults
    @(negedge clk); bus_rd = 1'b0; rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    bus_read(16'h4000);
    chk("R1 bank 1 after second reset", rom_addr, 21'h04000);
    bus_read(16'hA123);
    chk("R1 disabled after second reset", bus_rdata, 8'hFF);

    @(negedge clk); bus_rd = 1'b0;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule